// File: doc/BRIEF.md
# Fixed-Point ALU with Carry, Overflow and Condition Recording

This block is a 32-bit integer arithmetic and logic unit. It also holds the architectural flag state that goes with it. A strobed request carries two operands, a 3-bit operation code and three independent per-request enables. The enables say whether the request records its carry, records its overflow, and writes a condition field.

The unit keeps two pieces of state:
- A 3-bit flag register: carry, overflow, and a sticky summary-overflow bit.
- A 32-bit condition register made of eight 4-bit fields.

Field n occupies bits 4n through 4n+3. Only field 0 (bits 3:0) is written by this unit; the other fields stay cleared.

The result, the flags and the condition register all change on the single clock edge where the request strobe is high. Add-with-carry takes its carry-in from the carry flag as it stood before that edge. Every condition-field write also copies in the summary-overflow bit, so a later reader of the field sees whether any overflow has happened since reset.

Top module: `fx_alu`

## Requirements
- R1: With op code 0 (add), the result is a+b modulo 2^32; when the carry enable is set, the carry flag (flags bit 0) takes the carry out of bit 31 of the unsigned sum.
- R2: With op code 1 (add with carry), the result is a+b+c modulo 2^32, where c is the carry flag before the request; carry and overflow are computed over the full three-input sum.
- R3: When the overflow enable is set and the operation has no signed overflow, the overflow flag (flags bit 1) is cleared and summary-overflow (flags bit 2) keeps its value.
- R4: When the overflow enable is set and the operation has a signed overflow, both overflow and summary-overflow are set. Summary-overflow is cleared only by reset.
- R5: With the carry enable clear the carry flag keeps its value; with the overflow enable clear both overflow and summary-overflow keep their values.
- R6: Op codes 2, 3, 4 and 5 give a AND b, a OR b, a XOR b and NOT a. They produce neither carry nor overflow, so enabled flags are cleared (summary-overflow held).
- R7: With the record enable set, condition field 0 becomes {negative, positive, zero, summary-overflow} in bits 3..0. Exactly one of bits 3..1 is set, from a signed compare of the result with zero, and bit 0 is the summary-overflow after this request. With the record enable clear the condition register is unchanged; bits 31:4 always read zero.
- R8: While the request strobe is low, the result, flags and condition register do not change.
- R9: Reset clears the result, all flags and the condition register.
- R10: Op codes 6 and 7 give a zero result with no carry and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe; state updates on this edge |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| ca_en_i | input | 1 | Record carry for this request |
| ov_en_i | input | 1 | Record overflow for this request |
| rc_en_i | input | 1 | Write condition field 0 for this request |
| result_o | output | 32 | Registered result |
| flags_o | output | 3 | {summary-overflow, overflow, carry} |
| cond_o | output | 32 | Condition register |

## Verification
A wrong carry flag stays hidden until the next add-with-carry. It then appears in result_o one edge after that request, so the bench follows every carry-changing step with an add-with-carry or a direct look at flags_o. A lost or spuriously set summary-overflow appears in bit 0 of every later condition write, and it persists. The bench therefore reads cond_o after each recorded request, on the edge after the strobe. Hold behaviour is checked by issuing requests with the enables clear and confirming that flags_o and cond_o are unchanged one cycle later.

// File: rtl/fx_alu_pkg.sv
package fx_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } flags_t;

  localparam int unsigned FLD_W = 4;
endpackage

// File: rtl/fx_alu_core.sv
module fx_alu_core
  import fx_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              ovf_o
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] sum;
  logic             cin_eff;

  always_comb begin
    cin_eff = (op_i == OP_ADDC) ? cin_i : 1'b0;
    sum     = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_eff};
    res_o   = '0;
    cout_o  = 1'b0;
    ovf_o   = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC: begin
        res_o  = sum[DATA_W-1:0];
        cout_o = sum[DATA_W];
        // same-sign operands with a sign change in the sum
        ovf_o  = (a_i[DATA_W-1] == b_i[DATA_W-1]) &&
                 (sum[DATA_W-1] != a_i[DATA_W-1]);
      end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NOT:  res_o = ~a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/fx_alu_flags.sv
module fx_alu_flags
  import fx_alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  logic   ca_en_i,
  input  logic   ov_en_i,
  input  logic   cout_i,
  input  logic   ovf_i,
  output flags_t flags_o,
  output logic   so_next_o
);
  flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (ca_en_i) flags_d.ca = cout_i;
    if (ov_en_i) begin
      flags_d.ov = ovf_i;
      flags_d.so = flags_q.so | ovf_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (upd_i) flags_q <= flags_d;
  end

  assign flags_o   = flags_q;
  assign so_next_o = flags_d.so;
endmodule

// File: rtl/fx_alu_cond.sv
module fx_alu_cond
  import fx_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_FLD = 8,
  parameter int unsigned TGT_FLD = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic [DATA_W-1:0]        res_i,
  input  logic                     so_i,
  output logic [NUM_FLD*FLD_W-1:0] cond_o
);
  logic             neg, zero, pos;
  logic [FLD_W-1:0] fld_d;

  always_comb begin
    neg   = res_i[DATA_W-1];
    zero  = (res_i == '0);
    pos   = !neg && !zero;
    fld_d = {neg, pos, zero, so_i};
  end

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    if (f == TGT_FLD) begin : g_wr
      logic [FLD_W-1:0] fld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    fld_q <= '0;
        else if (upd_i) fld_q <= fld_d;
      end
      assign cond_o[f*FLD_W +: FLD_W] = fld_q;
    end else begin : g_zero
      assign cond_o[f*FLD_W +: FLD_W] = '0;
    end
  end
endmodule

// File: rtl/fx_alu.sv
module fx_alu
  import fx_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_FLD = 8,
  localparam int unsigned CR_W   = NUM_FLD * FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              ca_en_i,
  input  logic              ov_en_i,
  input  logic              rc_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic [2:0]        flags_o,
  output logic [CR_W-1:0]   cond_o
);
  logic [DATA_W-1:0] core_res, res_q;
  logic              core_cout, core_ovf, so_next;
  flags_t            flags;

  fx_alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (flags.ca),
    .res_o  (core_res),
    .cout_o (core_cout),
    .ovf_o  (core_ovf)
  );

  fx_alu_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (valid_i),
    .ca_en_i   (ca_en_i),
    .ov_en_i   (ov_en_i),
    .cout_i    (core_cout),
    .ovf_i     (core_ovf),
    .flags_o   (flags),
    .so_next_o (so_next)
  );

  fx_alu_cond #(.DATA_W(DATA_W), .NUM_FLD(NUM_FLD), .TGT_FLD(0)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (valid_i && rc_en_i),
    .res_i  (core_res),
    .so_i   (so_next),
    .cond_o (cond_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_q <= '0;
    else if (valid_i) res_q <= core_res;
  end

  assign result_o = res_q;
  assign flags_o  = flags;
endmodule

// File: rtl/fx_alu_chk.sv
module fx_alu_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CR_W   = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic              ca_en_i,
  input logic              ov_en_i,
  input logic              rc_en_i,
  input logic [DATA_W-1:0] result_o,
  input logic [2:0]        flags_o,
  input logic [CR_W-1:0]   cond_o
);
  logic logic_op;
  assign logic_op = (op_i >= 3'd2) && (op_i <= 3'd5);

  AST_LOGIC_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ov_en_i && logic_op |=> !flags_o[1] && (flags_o[2] == $past(flags_o[2]))); // R3
  AST_SO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[2] |=> flags_o[2]); // R4
  AST_OV_IMPLIES_SO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] |-> flags_o[2]); // R4
  AST_CARRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ca_en_i |=> $stable(flags_o[0])); // R5
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ov_en_i |=> $stable(flags_o[2:1])); // R5
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ca_en_i && logic_op |=> !flags_o[0]); // R6
  AST_CR_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rc_en_i |=> $countones(cond_o[3:1]) == 1); // R7
  AST_CR_SO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rc_en_i |=> cond_o[0] == flags_o[2]); // R7
  AST_CR_NO_RC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !rc_en_i |=> $stable(cond_o)); // R7
  AST_CR_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_o[CR_W-1:4] == '0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flags_o) && $stable(cond_o)); // R8
endmodule

bind fx_alu fx_alu_chk #(.DATA_W(DATA_W), .CR_W(CR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .ca_en_i  (ca_en_i),
  .ov_en_i  (ov_en_i),
  .rc_en_i  (rc_en_i),
  .result_o (result_o),
  .flags_o  (flags_o),
  .cond_o   (cond_o)
);

// File: tb/sim_fx_alu.sv
module sim_fx_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        ca_en = 1'b0, ov_en = 1'b0, rc_en = 1'b0;
  logic [31:0] result;
  logic [2:0]  flags;
  logic [31:0] cond;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of architectural state
  logic [31:0] m_res = '0;
  logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;
  logic [3:0]  m_fld = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx_alu u0 (
    .clk_i (clk), .rst_ni (rst_ni), .valid_i (valid), .op_i (op),
    .a_i (a), .b_i (b), .ca_en_i (ca_en), .ov_en_i (ov_en), .rc_en_i (rc_en),
    .result_o (result), .flags_o (flags), .cond_o (cond)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " result"}, result, m_res);
    chk({req, " flags"}, {29'd0, flags}, {29'd0, m_so, m_ov, m_ca});
    chk({req, " cond"}, cond, {28'd0, m_fld});
  endtask

  task automatic model(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                       logic ce, logic oe, logic re);
    logic [32:0] s;
    logic        c, v;
    logic [31:0] r;
    c = 1'b0; v = 1'b0;
    s = {1'b0, x} + {1'b0, y} + ((o == 3'd1) ? {32'd0, m_ca} : 33'd0);
    case (o)
      3'd0, 3'd1: begin
        r = s[31:0]; c = s[32];
        v = (x[31] == y[31]) && (s[31] != x[31]);
      end
      3'd2: r = x & y;
      3'd3: r = x | y;
      3'd4: r = x ^ y;
      3'd5: r = ~x;
      default: r = 32'd0;
    endcase
    m_res = r;
    if (ce) m_ca = c;
    if (oe) begin m_ov = v; if (v) m_so = 1'b1; end
    if (re) m_fld = {r[31], !r[31] && (r != 0), r == 0, m_so};
  endtask

  // drive at a falling edge, sample one falling edge after the capturing rise
  task automatic issue(logic [2:0] o, logic [31:0] x, logic [31:0] y,
                       logic ce, logic oe, logic re);
    op = o; a = x; b = y; ca_en = ce; ov_en = oe; rc_en = re; valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    model(o, x, y, ce, oe, re);
  endtask

  task automatic t_reset;
    chk("R9 reset result", result, 32'd0);
    chk("R9 reset flags", {29'd0, flags}, 32'd0);
    chk("R9 reset cond", cond, 32'd0);
  endtask

  task automatic t_add;
    issue(3'd0, 32'd5, 32'd7, 1, 1, 1);
    chk("R1 add 5+7", result, 32'd12);
    chk("R7 positive field", cond, 32'h4);
    chk_all("R1 add");
    issue(3'd0, 32'hFFFF_FFFF, 32'd1, 1, 0, 1);
    chk("R1 carry out", {31'd0, flags[0]}, 32'd1);
    chk("R7 zero field", cond, 32'h2);
    chk_all("R1 wrap");
  endtask

  task automatic t_carry_hold;
    issue(3'd0, 32'd1, 32'd1, 0, 0, 0);
    chk("R5 carry held", {31'd0, flags[0]}, 32'd1);
    chk_all("R5 carry hold");
  endtask

  task automatic t_addc;
    issue(3'd1, 32'd0, 32'd0, 1, 0, 1);
    chk("R2 addc uses carry", result, 32'd1);
    chk_all("R2 addc set");
    issue(3'd1, 32'd10, 32'd20, 1, 0, 0);
    chk("R2 addc no carry-in", result, 32'd30);
    issue(3'd1, 32'hFFFF_FFFF, 32'd0, 1, 1, 0);
    chk_all("R2 addc zero");
    m_ca = m_ca;
  endtask

  task automatic t_overflow;
    issue(3'd0, 32'h7FFF_FFFF, 32'd1, 1, 1, 1);
    chk("R4 overflow flags", {29'd0, flags}, 32'h6);
    chk("R7 negative with so", cond, 32'h9);
    chk_all("R4 overflow");
    issue(3'd0, 32'h8000_0000, 32'h8000_0000, 1, 1, 0);
    chk_all("R4 negative overflow");
  endtask

  task automatic t_no_overflow;
    issue(3'd0, 32'd1, 32'd1, 0, 1, 1);
    chk("R3 ov cleared so kept", {29'd0, flags[2:1], 1'b0}, 32'h4);
    chk("R7 so in field", cond, 32'h5);
    chk_all("R3 no overflow");
  endtask

  task automatic t_ov_hold;
    issue(3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 0);
    issue(3'd0, 32'd2, 32'd3, 0, 0, 0);
    chk("R5 overflow held", {31'd0, flags[1]}, 32'd1);
    chk_all("R5 ov hold");
  endtask

  task automatic t_logic;
    issue(3'd2, 32'hF0F0_1234, 32'hFF00_FFFF, 1, 1, 1);
    chk("R6 and", result, 32'hF000_1234);
    chk("R6 no carry no ov", {30'd0, flags[1:0]}, 32'd0);
    chk_all("R6 and");
    issue(3'd3, 32'h0000_00F0, 32'h0F00_000F, 1, 1, 1);
    chk_all("R6 or");
    issue(3'd4, 32'hAAAA_5555, 32'hFFFF_0000, 1, 1, 1);
    chk_all("R6 xor");
    issue(3'd5, 32'h0000_0000, 32'h1234_5678, 1, 1, 1);
    chk("R6 not", result, 32'hFFFF_FFFF);
    chk_all("R6 not");
  endtask

  task automatic t_rc_off;
    issue(3'd0, 32'd0, 32'd0, 1, 1, 0);
    chk("R7 cond unchanged", cond, {28'd0, m_fld});
    chk_all("R7 rc off");
  endtask

  task automatic t_idle;
    op = 3'd0; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
    ca_en = 1; ov_en = 1; rc_en = 1; valid = 1'b0;
    repeat (2) @(negedge clk);
    chk_all("R8 idle");
  endtask

  task automatic t_reserved;
    issue(3'd0, 32'hFFFF_FFFF, 32'd5, 1, 0, 0);
    issue(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1);
    chk("R10 op6 zero", result, 32'd0);
    chk_all("R10 op6");
    issue(3'd7, 32'h1234, 32'h5678, 1, 1, 1);
    chk_all("R10 op7");
  endtask

  task automatic t_reset_again;
    rst_ni = 1'b0;
    @(negedge clk);
    m_res = '0; m_ca = 0; m_ov = 0; m_so = 0; m_fld = '0;
    chk_all("R9 second reset");
    chk("R4 so cleared by reset", {31'd0, flags[2]}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    issue(3'd0, 32'd3, 32'hFFFF_FFFC, 1, 1, 1);
    chk("R7 negative no so", cond, 32'h8);
    chk_all("R9 after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_add();
    t_carry_hold();
    t_addc();
    t_overflow();
    t_no_overflow();
    t_ov_hold();
    t_logic();
    t_rc_off();
    t_idle();
    t_reserved();
    t_reset_again();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule